// File: doc/BRIEF.md
# Link-Accumulator Shift and Rotate Unit

This unit carries out the shift and rotate group of a small word-oriented processor. It takes the current instruction word together with the 16-bit accumulator and the 1-bit link. When the word belongs to the group and is enabled, the unit produces the accumulator and link values that the instruction leaves behind. Rotates treat the link and the accumulator as one 17-bit ring. Arithmetic shifts in either direction leave the sign bit (bit 15) where it is.

The result is registered. Whatever operands are presented before a rising edge appear on the outputs after that edge, for every count from one to three, so a new instruction can be issued on each cycle. Three kinds of word pass the accumulator and link through unchanged: a word outside the group, a disabled cycle, and a group word whose count field is zero. The last of these also raises an illegal flag for one cycle, which the surrounding control logic can turn into a trap.

Top module: `shrot_unit`

## Requirements
- R1: A word belongs to the group when bits 15..6 equal 0000011000 and bits 3..2 are zero. Bits 5..4 pick the operation (00 rotate left, 01 rotate right, 10 arithmetic shift left, 11 arithmetic shift right) and bits 1..0 give the count.
- R2: Rotate left, applied count times, moves accumulator bit 15 into the link and the previous link into accumulator bit 0.
- R3: Rotate right, applied count times, moves accumulator bit 0 into the link and the previous link into accumulator bit 15.
- R4: Arithmetic shift left keeps bit 15. It moves bits 14..0 left by the count with zero fill, drops bits that pass bit 14, and leaves the link unchanged.
- R5: Arithmetic shift right copies bit 15 into every vacated position and leaves the link unchanged.
- R6: An enabled group word with a count of zero sets the illegal output for that result cycle and passes the accumulator and link through unchanged, for all four operations.
- R7: With enable low, the accumulator and link outputs equal the inputs and the illegal output is low, whatever the word is.
- R8: An enabled word outside the group passes the accumulator and link through and keeps the illegal output low.
- R9: Every result, for any count, appears on the outputs after the first rising edge following its inputs, and back-to-back instructions give back-to-back results.
- R10: While reset is low at a rising edge, the accumulator output, link output and illegal output are all cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Execute enable for the presented word |
| insn | input | 16 | Instruction word |
| acc_in | input | 16 | Current accumulator value |
| link_in | input | 1 | Current link value |
| acc_out | output | 16 | Accumulator after the instruction |
| link_out | output | 1 | Link after the instruction |
| illegal | output | 1 | Group word with a count of zero was enabled |

## Verification
Because the unit keeps no state from one instruction to the next, a fault in its decode or its stage chain shows up on the very first result cycle that uses the faulty path. A wrong stage select shows up as an accumulator off by one bit position, or as a link that is wrong in rotates and changed in shifts. The test words are chosen so that the bits crossing between the link and the accumulator differ, so a rotate that bypasses the link, or a left shift that lets a bit cross into bit 15, changes the result. Words that sit just outside the group (bit 2 set, bit 6 set, bit 15 set) and zero-count words catch decode faults in the same cycle.

// File: rtl/shrot_pkg.sv
// Shared types for the shift/rotate unit.
// Assumes the 16-bit instruction layout given in the brief.
package shrot_pkg;

    localparam int CNT_W = 2;

    typedef enum logic [1:0] {
        OP_ROL = 2'b00,
        OP_ROR = 2'b01,
        OP_ASL = 2'b10,
        OP_ASR = 2'b11
    } shrot_op_e;

    typedef struct packed {
        logic             hit;   // word is in the shift/rotate group
        logic             bad;   // group word with count zero
        shrot_op_e        op;
        logic [CNT_W-1:0] cnt;
    } shrot_dec_t;

endpackage

// File: rtl/shrot_decode.sv
// Instruction decoder: recognises shift/rotate group words and splits
// them into operation and count. Purely combinational.
// Assumes INSN_W >= 7; group code sits in bits INSN_W-1..6.
module shrot_decode
    import shrot_pkg::*;
#(
    parameter int INSN_W = 16
) (
    input  logic [INSN_W-1:0] insn,
    output shrot_dec_t        dec
);

    localparam int HI_W = INSN_W - 6;
    localparam logic [HI_W-1:0] GROUP_CODE = HI_W'(24);

    // Split the word into group match, operation and count fields.
    always_comb begin
        dec.hit = (insn[INSN_W-1:6] == GROUP_CODE) && (insn[3:2] == 2'b00);
        dec.op  = shrot_op_e'(insn[5:4]);
        dec.cnt = insn[CNT_W-1:0];
        dec.bad = dec.hit && (insn[CNT_W-1:0] == '0);
    end

endmodule

// File: rtl/shrot_core.sv
// Shift/rotate datapath: computes all four operations for the given
// count and selects one. Combinational, one cycle for any count.
// Assumes DATA_W >= 2; a count of zero yields the operands unchanged.
module shrot_core
    import shrot_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  shrot_op_e         op,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] acc,
    input  logic              link,
    output logic [DATA_W-1:0] acc_nx,
    output logic              link_nx
);

    localparam int MAX_STEPS = (1 << CNT_W) - 1;
    localparam int RING_W    = DATA_W + 1;

    logic [RING_W-1:0] rol_st [0:MAX_STEPS];
    logic [RING_W-1:0] ror_st [0:MAX_STEPS];
    logic [RING_W-1:0] rol_sel, ror_sel;
    logic [DATA_W-1:0] asl_res, asr_res;

    assign rol_st[0] = {link, acc};
    assign ror_st[0] = {link, acc};

    // Unrolled ring stages, one per possible count value.
    for (genvar s = 0; s < MAX_STEPS; s++) begin : g_ring
        assign rol_st[s+1] = {rol_st[s][RING_W-2:0], rol_st[s][RING_W-1]};
        assign ror_st[s+1] = {ror_st[s][0], ror_st[s][RING_W-1:1]};
    end

    assign rol_sel = rol_st[cnt];
    assign ror_sel = ror_st[cnt];

    // Arithmetic shifts: sign bit held, link untouched.
    always_comb begin
        asl_res = {acc[DATA_W-1], acc[DATA_W-2:0] << cnt};
        asr_res = DATA_W'($signed(acc) >>> cnt);
    end

    // Pick the result of the decoded operation.
    always_comb begin
        unique case (op)
            OP_ROL:  {link_nx, acc_nx} = rol_sel;
            OP_ROR:  {link_nx, acc_nx} = ror_sel;
            OP_ASL:  {link_nx, acc_nx} = {link, asl_res};
            default: {link_nx, acc_nx} = {link, asr_res};
        endcase
    end

endmodule

// File: rtl/shrot_unit.sv
// Top of the shift/rotate unit: decodes the word, runs the datapath and
// registers accumulator, link and illegal flag. Non-group, disabled and
// zero-count words pass the operands through.
// Assumes a synchronous active-low reset and one instruction per cycle.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int INSN_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              link_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              link_out,
    output logic              illegal
);

    shrot_dec_t        dec;
    logic [DATA_W-1:0] core_acc;
    logic              core_link;
    logic              do_op;

    shrot_decode #(.INSN_W(INSN_W)) u_dec (
        .insn (insn),
        .dec  (dec)
    );

    shrot_core #(.DATA_W(DATA_W)) u_core (
        .op      (dec.op),
        .cnt     (dec.cnt),
        .acc     (acc_in),
        .link    (link_in),
        .acc_nx  (core_acc),
        .link_nx (core_link)
    );

    // Execute only enabled, legal group words.
    assign do_op = en && dec.hit && !dec.bad;

    // Result register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_out  <= '0;
            link_out <= 1'b0;
            illegal  <= 1'b0;
        end else begin
            acc_out  <= do_op ? core_acc  : acc_in;
            link_out <= do_op ? core_link : link_in;
            illegal  <= en && dec.bad;
        end
    end

    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (acc_out == $past(acc_in)) && (link_out == $past(link_in)) && !illegal); // R7

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && insn[15:6] == 10'd24 && insn[3:0] == 4'd0)
        |=> illegal && (acc_out == $past(acc_in)) && (link_out == $past(link_in))); // R6

    AST_RING_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && insn[15:6] == 10'd24 && insn[3:2] == 2'd0 && !insn[5] && insn[1:0] != 2'd0)
        |=> $countones({link_out, acc_out}) == $countones($past({link_in, acc_in}))); // R2

    AST_SIGN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && insn[15:6] == 10'd24 && insn[3:2] == 2'd0 && insn[5])
        |=> (acc_out[DATA_W-1] == $past(acc_in[DATA_W-1])) && (link_out == $past(link_in))); // R5

    AST_FOREIGN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && insn[15:6] != 10'd24)
        |=> !illegal && (acc_out == $past(acc_in)) && (link_out == $past(link_in))); // R8

endmodule

// File: tb/shrot_unit_tb_top.sv
`timescale 1ns/1ps
module shrot_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [15:0] insn;
    logic [15:0] acc_in;
    logic        link_in;
    logic [15:0] acc_out;
    logic        link_out;
    logic        illegal;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shrot_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .insn     (insn),
        .acc_in   (acc_in),
        .link_in  (link_in),
        .acc_out  (acc_out),
        .link_out (link_out),
        .illegal  (illegal)
    );

    localparam int NV = 16;
    // Columns: requirement, enable, word, acc, link, expected acc, link, illegal.
    localparam string       V_REQ  [NV] = '{"R2","R2","R3","R3","R4","R4","R5","R5",
                                            "R5","R2","R6","R6","R8","R8","R8","R7"};
    localparam logic        V_EN   [NV] = '{1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,0};
    localparam logic [15:0] V_INSN [NV] = '{16'h0601,16'h0603,16'h0611,16'h0612,
                                            16'h0621,16'h0623,16'h0632,16'h0633,
                                            16'h0631,16'h0602,16'h0610,16'h0620,
                                            16'h0640,16'h0604,16'h8603,16'h0601};
    localparam logic [15:0] V_ACC  [NV] = '{16'h8001,16'hA000,16'h0001,16'h0003,
                                            16'h4001,16'h9FFF,16'h8004,16'h7FF8,
                                            16'h0001,16'h0000,16'h1234,16'hBEEF,
                                            16'h5555,16'h00FF,16'h0F0F,16'h8001};
    localparam logic        V_LNK  [NV] = '{0,1,0,1,1,0,1,0,0,1,1,0,1,0,1,0};
    localparam logic [15:0] V_XACC [NV] = '{16'h0002,16'h0006,16'h0000,16'hC000,
                                            16'h0002,16'hFFF8,16'hE001,16'h0FFF,
                                            16'h0000,16'h0002,16'h1234,16'hBEEF,
                                            16'h5555,16'h00FF,16'h0F0F,16'h8001};
    localparam logic        V_XLNK [NV] = '{1,1,1,1,1,0,1,0,0,0,1,0,1,0,1,0};
    localparam logic        V_XILL [NV] = '{0,0,0,0,0,0,0,0,0,0,1,1,0,0,0,0};

    task automatic check(input string req, input logic [15:0] xa,
                         input logic xl, input logic xi);
        n_chk++;
        if (acc_out !== xa || link_out !== xl || illegal !== xi) begin
            n_fail++;
            $display("FAIL %s: got acc=%h link=%b ill=%b, expected acc=%h link=%b ill=%b",
                     req, acc_out, link_out, illegal, xa, xl, xi);
        end
    endtask

    task automatic drive(input logic e, input logic [15:0] w,
                         input logic [15:0] a, input logic l);
        en = e; insn = w; acc_in = a; link_in = l;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 16'h0601, 16'hFFFF, 1'b1);
        repeat (2) @(negedge clk);
        // R10: reset clears outputs despite active inputs
        check("R10", 16'h0000, 1'b0, 1'b0);
        rst_n = 1'b1;

        // Table walk; one rising edge between drive and sample (R1 decode fields)
        for (int i = 0; i < NV; i++) begin
            drive(V_EN[i], V_INSN[i], V_ACC[i], V_LNK[i]);
            @(negedge clk);
            check(V_REQ[i], V_XACC[i], V_XLNK[i], V_XILL[i]);
        end

        // R9: back-to-back instructions give back-to-back results
        drive(1'b1, 16'h0603, 16'hA000, 1'b1);
        @(negedge clk);
        check("R9", 16'h0006, 1'b1, 1'b0);
        drive(1'b1, 16'h0630, 16'h4321, 1'b0);
        @(negedge clk);
        check("R9", 16'h4321, 1'b0, 1'b1);
        drive(1'b1, 16'h0612, 16'h0003, 1'b1);
        @(negedge clk);
        check("R9", 16'hC000, 1'b1, 1'b0);

        // R6: zero-count rotate left is illegal too
        drive(1'b1, 16'h0600, 16'h8000, 1'b0);
        @(negedge clk);
        check("R6", 16'h8000, 1'b0, 1'b1);

        // R7: disabled zero-count word raises no illegal flag
        drive(1'b0, 16'h0610, 16'h00AA, 1'b1);
        @(negedge clk);
        check("R7", 16'h00AA, 1'b1, 1'b0);

        // R4: bit 14 shifted out must not reach bit 15
        drive(1'b1, 16'h0621, 16'h4000, 1'b0);
        @(negedge clk);
        check("R4", 16'h0000, 1'b0, 1'b0);

        // R10: reset mid-stream clears a nonzero result
        drive(1'b1, 16'h0601, 16'h8001, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", 16'h0000, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule